// File: doc/BRIEF.md
# Load-Port Handoff Controller with Watchdogs

This block follows the parallel handshake between a transport vehicle and a load port. It samples eight handshake lines once per clock: two carrier-select lines, the handoff valid line, load request, unload request, move busy, move done and emergency stop. From these lines it keeps a handshake state.

Three watchdogs supervise the handshake. Each one belongs to a single leg of it. The acknowledge watchdog limits how long the port takes to answer a valid offer. The start watchdog limits how long the vehicle takes to start moving once the port is ready. The move watchdog limits how long the busy phase lasts. Each watchdog is a down-counter. It loads its programmed limit when its state is entered and counts down once per millisecond tick.

When an armed watchdog runs out, the controller enters a fault state. It stays in that state and keeps a reason code until a synchronous clear. While the fault is held, no handshake line has any effect.

The states and their output codes on `state_o` are:

| Code | State | Meaning |
|------|-------|---------|
| 0 | ST_IDLE | All lines are low |
| 1 | ST_CARRIER | A carrier is selected |
| 2 | ST_OFFER | The valid line is high |
| 3 | ST_LOAD_RDY | The port is ready to load |
| 4 | ST_UNLOAD_RDY | The port is ready to unload |
| 5 | ST_MOVING | The vehicle is busy moving |
| 6 | ST_DONE | The move is complete |
| 7 | ST_ESTOP | Emergency stop |
| 8 | ST_FAULT | A watchdog ran out; the fault is held |

Transitions:
- Every state except ST_FAULT moves to the state that the current lines decode to.
- A state moves to ST_FAULT when its own watchdog runs out and the lines leave it in the same state.
- ST_FAULT leaves only on clear, and it goes to ST_IDLE.
- Clear takes any state to ST_IDLE.

Top module: `lp_handoff_ctrl`

## Requirements
- R1: The state codes are 0 to 8, in the order of the table above. After reset, `state_o`=0, `fault_code_o`=0, `armed_o`=3'b000 and `fault_pulse_o`=0.
- R2: The lines decode with a fixed priority, from highest to lowest: estop→7, move_done→6, move_busy→5, load_req→3, unload_req→4, hand_valid→2, either select→1, otherwise 0. The decoded state appears on `state_o` one clock after the lines are sampled.
- R3: When estop is high and the block is not in fault, the next state is 7 and no watchdog is armed.
- R4: `armed_o` bit 0, the acknowledge watchdog, is the only armed watchdog while the state is 2.
- R5: `armed_o` bit 1, the start watchdog, is the only armed watchdog in states 3 and 4. When move busy drops in state 5, the block returns to the ready state and this watchdog arms again.
- R6: `armed_o` bit 2, the move watchdog, is the only armed watchdog in state 5. No watchdog is armed in states 0, 1, 6, 7 or 8.
- R7: A watchdog whose limit is 0 never arms, however many ticks arrive.
- R8: Consider an armed watchdog with limit N that sees N tick cycles without a state change. On the next clock edge the state becomes 8. `fault_code_o` becomes 1, 2 or 3 for the acknowledge, start or move watchdog. `fault_pulse_o` is high for exactly that one cycle.
- R9: In state 8 without clear, every line change and every tick leaves the state and the fault code unchanged.
- R10: A watchdog that runs out in the same cycle as the lines cause a state change is cancelled by that change. No fault follows.
- R11: Clear sets the state to 0, the fault code to 0 and `armed_o` to 0 on the next edge.
- R12: Entering a watchdog's state again reloads that watchdog's full limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the state, the fault and the watchdogs |
| tick_ms_i | input | 1 | One-cycle pulse once per millisecond |
| sel0_i | input | 1 | Carrier select 0 |
| sel1_i | input | 1 | Carrier select 1 |
| hand_valid_i | input | 1 | Handoff valid line from the vehicle |
| load_req_i | input | 1 | Load request from the port |
| unload_req_i | input | 1 | Unload request from the port |
| move_busy_i | input | 1 | Vehicle is moving the carrier |
| move_done_i | input | 1 | Vehicle reports that the move is complete |
| estop_i | input | 1 | Emergency stop |
| tmo_ack_i | input | TMO_W | Acknowledge watchdog limit in ticks; 0 disables it |
| tmo_start_i | input | TMO_W | Start watchdog limit in ticks; 0 disables it |
| tmo_move_i | input | TMO_W | Move watchdog limit in ticks; 0 disables it |
| state_o | output | 4 | Handshake state code |
| fault_code_o | output | 2 | Fault reason: 0 none, 1 acknowledge, 2 start, 3 move |
| fault_pulse_o | output | 1 | High for the one cycle in which the fault is entered |
| armed_o | output | 3 | Armed flag for each watchdog: bit 0 acknowledge, bit 1 start, bit 2 move |

## Verification
The assertions check these properties on every cycle:
- Emergency stop dominates.
- The fault holds until clear.
- Clear always lands in idle.
- No watchdog is armed in a state that has no watchdog.
- A watchdog that is armed reloads its full limit and counts only on ticks.

Only the bench scenarios can show the following:
- The exact tick count at which each watchdog fires.
- The reason code for each watchdog.
- Cancel winning over expiry in the same cycle.
- Reload on re-entry.
- The return to the ready state when busy drops.

// File: rtl/lp_handoff_pkg.sv
package lp_handoff_pkg;

    localparam int NUM_WD = 3;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_CARRIER    = 4'd1,
        ST_OFFER      = 4'd2,
        ST_LOAD_RDY   = 4'd3,
        ST_UNLOAD_RDY = 4'd4,
        ST_MOVING     = 4'd5,
        ST_DONE       = 4'd6,
        ST_ESTOP      = 4'd7,
        ST_FAULT      = 4'd8
    } hs_state_e;

    typedef struct packed {
        logic estop;
        logic done;
        logic busy;
        logic lreq;
        logic ureq;
        logic valid;
        logic sel1;
        logic sel0;
    } hs_lines_t;

    // Watchdog that belongs to a state: 0 none, 1 acknowledge, 2 start, 3 move
    function automatic logic [1:0] wd_owner(hs_state_e s);
        logic [1:0] r;
        unique case (s)
            ST_OFFER:                  r = 2'd1;
            ST_LOAD_RDY, ST_UNLOAD_RDY: r = 2'd2;
            ST_MOVING:                 r = 2'd3;
            default:                   r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lp_hs_decode.sv
module lp_hs_decode
    import lp_handoff_pkg::*;
(
    input  hs_lines_t lines_i,
    output hs_state_e line_state_o
);

    // Fixed priority: stop, done, busy, load, unload, valid, select
    always_comb begin
        if (lines_i.estop)                    line_state_o = ST_ESTOP;
        else if (lines_i.done)                line_state_o = ST_DONE;
        else if (lines_i.busy)                line_state_o = ST_MOVING;
        else if (lines_i.lreq)                line_state_o = ST_LOAD_RDY;
        else if (lines_i.ureq)                line_state_o = ST_UNLOAD_RDY;
        else if (lines_i.valid)               line_state_o = ST_OFFER;
        else if (lines_i.sel0 || lines_i.sel1) line_state_o = ST_CARRIER;
        else                                  line_state_o = ST_IDLE;
    end

endmodule

// File: rtl/lp_hs_watchdog.sv
module lp_hs_watchdog #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic             want_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             armed_o,
    output logic             expire_o
);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else if (reload_i) begin
            armed_q <= want_i;
            cnt_q   <= limit_i;
        end else if (armed_q && tick_i && cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    assign armed_o  = armed_q;
    assign expire_o = armed_q && (cnt_q == '0);

    assert_reload_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && want_i) |=> (armed_q && cnt_q == $past(limit_i)));

    assert_zero_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && limit_i == '0) |=> !armed_q);

    assert_tick_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !reload_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lp_handoff_ctrl.sv
module lp_handoff_ctrl
    import lp_handoff_pkg::*;
#(
    parameter int TMO_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             tick_ms_i,
    input  logic             sel0_i,
    input  logic             sel1_i,
    input  logic             hand_valid_i,
    input  logic             load_req_i,
    input  logic             unload_req_i,
    input  logic             move_busy_i,
    input  logic             move_done_i,
    input  logic             estop_i,
    input  logic [TMO_W-1:0] tmo_ack_i,
    input  logic [TMO_W-1:0] tmo_start_i,
    input  logic [TMO_W-1:0] tmo_move_i,
    output logic [3:0]       state_o,
    output logic [1:0]       fault_code_o,
    output logic             fault_pulse_o,
    output logic [2:0]       armed_o
);

    hs_lines_t         lines;
    hs_state_e         state_q, state_d, line_state;
    logic [1:0]        code_q, code_d;
    logic              pulse_q;
    logic              entry;
    logic [NUM_WD-1:0] expire, armed;
    logic [TMO_W-1:0]  limit [NUM_WD];

    assign lines = '{estop: estop_i, done: move_done_i, busy: move_busy_i,
                     lreq: load_req_i, ureq: unload_req_i, valid: hand_valid_i,
                     sel1: sel1_i, sel0: sel0_i};

    assign limit[0] = tmo_ack_i;
    assign limit[1] = tmo_start_i;
    assign limit[2] = tmo_move_i;

    lp_hs_decode u_decode (
        .lines_i      (lines),
        .line_state_o (line_state)
    );

    // Next state: clear, then fault hold, then a line change (which
    // cancels any expiry), then an expiry
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (clear_i) begin
            state_d = ST_IDLE;
            code_d  = 2'd0;
        end else if (state_q == ST_FAULT) begin
            state_d = ST_FAULT;
        end else if (line_state != state_q) begin
            state_d = line_state;
        end else if (|expire) begin
            state_d = ST_FAULT;
            for (int k = NUM_WD - 1; k >= 0; k--) begin
                if (expire[k]) code_d = 2'(k + 1);
            end
        end
    end

    assign entry = clear_i || (state_d != state_q);

    generate
        for (genvar i = 0; i < NUM_WD; i++) begin : g_wd
            localparam logic [1:0] WD_ID = 2'(i + 1);
            logic want;
            assign want = (wd_owner(state_d) == WD_ID) && (limit[i] != '0);
            lp_hs_watchdog #(.CNT_W(TMO_W)) u_wd (
                .clk      (clk),
                .rst_n    (rst_n),
                .reload_i (entry),
                .want_i   (want),
                .tick_i   (tick_ms_i),
                .limit_i  (limit[i]),
                .armed_o  (armed[i]),
                .expire_o (expire[i])
            );
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= (state_d == ST_FAULT) && (state_q != ST_FAULT);
    end

    assign state_o       = state_q;
    assign fault_code_o  = code_q;
    assign fault_pulse_o = pulse_q;
    assign armed_o       = armed;

    assert_estop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (estop_i && !clear_i && state_q != ST_FAULT) |=> (state_q == ST_ESTOP && armed_o == 3'b000));

    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && !clear_i) |=> (state_q == ST_FAULT && $stable(code_q)));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_q == ST_IDLE && code_q == 2'd0 && armed_o == 3'b000));

    assert_no_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_owner(state_q) == 2'd0) |-> (armed_o == 3'b000));

    assert_single_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(armed_o));

    assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse_o |-> (state_q == ST_FAULT && code_q != 2'd0));

endmodule

// File: tb/lp_handoff_ctrl_test.sv
module lp_handoff_ctrl_test;

    localparam logic [7:0] L_SEL0 = 8'h01, L_SEL1 = 8'h02, L_VAL = 8'h04, L_UREQ = 8'h08,
                           L_LREQ = 8'h10, L_BUSY = 8'h20, L_DONE = 8'h40, L_STOP = 8'h80;
    localparam logic [7:0] OFFER = L_SEL0 | L_VAL;
    localparam logic [7:0] LOADR = L_SEL0 | L_VAL | L_LREQ;
    localparam logic [7:0] MOVE  = L_SEL0 | L_VAL | L_LREQ | L_BUSY;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, tick = 1'b0, clr = 1'b0;
    logic [7:0]  lines = 8'h00;
    logic [16:0] t_ack = 17'd3, t_start = 17'd4, t_move = 17'd5;
    logic [3:0]  state;
    logic [1:0]  code;
    logic        pulse;
    logic [2:0]  armed;

    lp_handoff_ctrl uut (
        .clk(clk), .rst_n(rst_n), .clear_i(clr), .tick_ms_i(tick),
        .sel0_i(lines[0]), .sel1_i(lines[1]), .hand_valid_i(lines[2]),
        .unload_req_i(lines[3]), .load_req_i(lines[4]), .move_busy_i(lines[5]),
        .move_done_i(lines[6]), .estop_i(lines[7]),
        .tmo_ack_i(t_ack), .tmo_start_i(t_start), .tmo_move_i(t_move),
        .state_o(state), .fault_code_o(code), .fault_pulse_o(pulse), .armed_o(armed)
    );

    typedef struct {
        logic [3:0] st;
        logic [1:0] cd;
        logic [2:0] ar;
        logic       pl;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    // Driver: one cycle of stimulus, expectation for the following edge
    task automatic cyc(input logic [7:0] ln, input logic tk, input logic cl,
                       input logic [3:0] st, input logic [1:0] cd,
                       input logic [2:0] ar, input logic pl, input string tag);
        exp_t e;
        @(negedge clk);
        lines = ln; tick = tk; clr = cl;
        e.st = st; e.cd = cd; e.ar = ar; e.pl = pl; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (state !== e.st || code !== e.cd || armed !== e.ar || pulse !== e.pl) begin
                    n_fail++;
                    $display("FAIL %s: state=%0d code=%0d armed=%b pulse=%b, expected state=%0d code=%0d armed=%b pulse=%b",
                             e.tag, state, code, armed, pulse, e.st, e.cd, e.ar, e.pl);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(8'h00, 0, 0, 0, 0, 3'b000, 0, "R1 reset state");
        // R2 decode and R4/R5/R6 ownership along a load cycle
        cyc(L_SEL0, 0, 0, 1, 0, 3'b000, 0, "R2 carrier");
        cyc(OFFER,  0, 0, 2, 0, 3'b001, 0, "R4 offer arms ack");
        cyc(LOADR,  0, 0, 3, 0, 3'b010, 0, "R5 load ready");
        cyc(MOVE,   0, 0, 5, 0, 3'b100, 0, "R6 moving");
        cyc(LOADR,  0, 0, 3, 0, 3'b010, 0, "R5 busy drop rearms");
        cyc(LOADR | L_DONE, 0, 0, 6, 0, 3'b000, 0, "R6 done has no timer");
        cyc(8'h00,  0, 0, 0, 0, 3'b000, 0, "R2 idle");
        cyc(L_SEL1 | L_VAL | L_UREQ, 0, 0, 4, 0, 3'b010, 0, "R2 unload ready");
        cyc(L_SEL1 | L_VAL | L_UREQ | L_STOP, 0, 0, 7, 0, 3'b000, 0, "R3 estop");
        cyc(8'hFF,  0, 0, 7, 0, 3'b000, 0, "R2 estop priority");
        cyc(L_SEL0 | L_VAL | L_LREQ | L_UREQ, 0, 0, 3, 0, 3'b010, 0, "R2 load over unload");
        cyc(8'h00,  0, 0, 0, 0, 3'b000, 0, "R2 idle");
        // R7 zero limit
        t_ack = 17'd0;
        cyc(OFFER, 0, 0, 2, 0, 3'b000, 0, "R7 zero limit");
        for (int k = 0; k < 4; k++) cyc(OFFER, 1, 0, 2, 0, 3'b000, 0, "R7 ticks ignored");
        t_ack = 17'd3;
        cyc(L_SEL0, 0, 0, 1, 0, 3'b000, 0, "R2 valid drop");
        cyc(OFFER,  0, 0, 2, 0, 3'b001, 0, "R4 rearm");
        // R8 acknowledge expiry
        for (int k = 0; k < 3; k++) cyc(OFFER, 1, 0, 2, 0, 3'b001, 0, "R8 counting");
        cyc(OFFER, 0, 0, 8, 1, 3'b000, 1, "R8 ack expiry");
        cyc(8'hFF, 0, 0, 8, 1, 3'b000, 0, "R9 lines ignored");
        cyc(L_SEL0, 1, 0, 8, 1, 3'b000, 0, "R9 held");
        cyc(8'h00, 0, 1, 0, 0, 3'b000, 0, "R11 clear");
        // R12 reload on re-entry
        cyc(OFFER, 0, 0, 2, 0, 3'b001, 0, "R4 offer");
        for (int k = 0; k < 2; k++) cyc(OFFER, 1, 0, 2, 0, 3'b001, 0, "R12 partial count");
        cyc(L_SEL0, 0, 0, 1, 0, 3'b000, 0, "R12 leave");
        cyc(OFFER, 0, 0, 2, 0, 3'b001, 0, "R12 reenter");
        for (int k = 0; k < 2; k++) cyc(OFFER, 1, 0, 2, 0, 3'b001, 0, "R12 counting");
        cyc(OFFER, 0, 0, 2, 0, 3'b001, 0, "R12 no early expiry");
        cyc(OFFER, 1, 0, 2, 0, 3'b001, 0, "R12 last tick");
        cyc(OFFER, 0, 0, 8, 1, 3'b000, 1, "R12 full limit used");
        cyc(8'h00, 0, 1, 0, 0, 3'b000, 0, "R11 clear");
        // R10 cancel wins
        cyc(OFFER, 0, 0, 2, 0, 3'b001, 0, "R4 offer");
        for (int k = 0; k < 3; k++) cyc(OFFER, 1, 0, 2, 0, 3'b001, 0, "R10 run out");
        cyc(LOADR, 0, 0, 3, 0, 3'b010, 0, "R10 cancel wins");
        for (int k = 0; k < 4; k++) cyc(LOADR, 1, 0, 3, 0, 3'b010, 0, "R8 start counting");
        cyc(LOADR, 0, 0, 8, 2, 3'b000, 1, "R8 start expiry");
        cyc(8'h00, 0, 1, 0, 0, 3'b000, 0, "R11 clear");
        // Move watchdog
        cyc(MOVE, 0, 0, 5, 0, 3'b100, 0, "R6 moving");
        for (int k = 0; k < 5; k++) cyc(MOVE, 1, 0, 5, 0, 3'b100, 0, "R8 move counting");
        cyc(MOVE, 0, 0, 8, 3, 3'b000, 1, "R8 move expiry");
        cyc(MOVE, 0, 0, 8, 3, 3'b000, 0, "R8 pulse one cycle");
        cyc(8'h00, 0, 1, 0, 0, 3'b000, 0, "R11 clear");
        cyc(OFFER, 0, 0, 2, 0, 3'b001, 0, "R4 offer");
        cyc(OFFER, 0, 1, 0, 0, 3'b000, 0, "R11 clear while armed");
        cyc(8'h00, 0, 0, 0, 0, 3'b000, 0, "R1 idle");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule